// File: doc/BRIEF.md
# Overlapping Register Window File

This block is a register file whose windowed registers sit in a circular set of windows. Each logical register number is remapped through a rotating current-window pointer. The register view of a procedure has four groups of eight: globals, incoming arguments, locals and outgoing arguments. The outgoing group of one window is the same storage as the incoming group of the next window, so a caller hands arguments to its callee without moving any data. The globals sit outside the rotation and are seen from every window.

A call pulse moves the window pointer forward and a return pulse moves it back. The circular buffer can fill up. When a call would reach storage that an older frame still owns, the block stalls, raises an overflow flag and writes the oldest resident frame to memory, one word per accepted handshake. A return into a frame that was moved out reloads that frame from memory before the return completes. During either transfer a busy output tells the issuing pipeline to hold its call, return and write requests.

Top module: `rwin_file`

## Requirements
- R1: After reset the current window pointer is 0, the spill pointer is NWIN-1, busy, overflow, underflow and memory valid are low, and every register reads 0.
- R2: Logical numbers 0-7 select eight global registers that hold the same contents whatever the window pointer is.
- R3: A logical number r in 8-31 maps to windowed entry (cwp*16 + r - 8) mod (NWIN*16), so logical 24-31 in window w is the same storage as logical 8-15 in window w+1.
- R4: Without a trap, a call raises the window pointer by one (mod NWIN) and a return lowers it by one. Each takes effect at the next clock edge and busy stays low.
- R5: A call made while cwp+1 equals the spill pointer (mod NWIN) raises busy and the overflow flag from the next cycle. The window pointer advances only when the spill ends.
- R6: A spill writes 16 words, with mem_we_o high, to addresses frames*16+k. Here frames is the number of frames already in memory, k 0-7 are the incoming-argument registers and k 8-15 are the locals of the oldest resident window (spill pointer + 1). Valid and address stay unchanged until ready is seen.
- R7: The spill pointer rises by one at the end of each spill and falls by one at the end of each fill.
- R8: A return while cwp equals spill pointer + 1 and at least one frame is in memory raises busy and the underflow flag. It reads words (frames-1)*16+k with mem_we_o low into the incoming and local registers of window cwp-1. It then lowers cwp, and the restored values read back unchanged.
- R9: A return while cwp equals spill pointer + 1 and no frame is in memory changes nothing.
- R10: While busy is high, call, return and write requests are ignored.
- R11: Two read ports return the addressed registers combinationally and independently, and a write is visible from the cycle after its clock edge.
- R12: Call and return asserted in the same cycle leave the window pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| call_i | input | 1 | Procedure call request |
| ret_i | input | 1 | Procedure return request |
| rd_a_addr_i | input | 5 | Logical register number, read port A |
| rd_a_data_o | output | 32 | Read data, port A |
| rd_b_addr_i | input | 5 | Logical register number, read port B |
| rd_b_data_o | output | 32 | Read data, port B |
| wr_en_i | input | 1 | Write enable |
| wr_addr_i | input | 5 | Logical register number for the write |
| wr_data_i | input | 32 | Write data |
| busy_o | output | 1 | Spill or fill in progress; hold requests |
| ovf_o | output | 1 | Overflow trap: spill in progress |
| unf_o | output | 1 | Underflow trap: fill in progress |
| cwp_o | output | 3 | Current window pointer |
| swp_o | output | 3 | Spill pointer (window spilled most recently) |
| mem_valid_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | 1 = spill write, 0 = fill read |
| mem_addr_o | output | 12 | Word address in the spill area |
| mem_wdata_o | output | 32 | Spill write data |
| mem_ready_i | input | 1 | Memory accepts the request (read data valid in the same cycle) |
| mem_rdata_i | input | 32 | Fill read data |

## Verification
A window pointer that is off by one shows up in the first read after a call: the incoming arguments no longer match the caller's outgoing ones, and the same mistake appears on cwp_o in that cycle. A wrong spill pointer or frame count is hidden until the next trap. Then the trap starts one call too early or too late, or a spill lands at the wrong memory frame. Restored locals that read back wrong after the matching return expose that kind of error, so the bench drives call chains deep enough to wrap the buffer more than once and then unwinds them fully.

// File: rtl/rwin_pkg.sv
package rwin_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_SPILL = 2'd1,
    SQ_FILL  = 2'd2
  } seq_state_e;

  // region code taken from the top two bits of a logical register number
  localparam logic [1:0] RG_GLOBAL = 2'd0;
endpackage

// File: rtl/rwin_map.sv
module rwin_map #(
  parameter int NWIN = 8,
  parameter int NREG = 8,
  localparam int WIN_W = $clog2(NWIN),
  localparam int OFF_W = $clog2(NREG),
  localparam int LA_W  = OFF_W + 2,
  localparam int WI_W  = WIN_W + OFF_W + 1,
  localparam int NWREG = NWIN * 2 * NREG,
  localparam int PI_W  = $clog2(NWREG + NREG)
) (
  input  logic [LA_W-1:0]  la_i,
  input  logic [WIN_W-1:0] cwp_i,
  output logic [PI_W-1:0]  pidx_o
);
  import rwin_pkg::*;

  logic [1:0]       region;
  logic [1:0]       region_m1;
  logic [OFF_W-1:0] off;
  logic [WI_W-1:0]  base, rel, wsum;

  always_comb begin
    region    = la_i[LA_W-1 -: 2];
    off       = la_i[OFF_W-1:0];
    region_m1 = region - 2'd1;
    base      = {cwp_i, {(OFF_W+1){1'b0}}};
    rel       = WI_W'({region_m1, off});
    wsum      = base + rel;  // wraps at the end of windowed storage
    if (region == RG_GLOBAL) pidx_o = PI_W'(NWREG) + PI_W'(off);
    else                     pidx_o = PI_W'(wsum);
  end
endmodule

// File: rtl/rwin_store.sv
module rwin_store #(
  parameter int DW   = 32,
  parameter int NENT = 136,
  parameter int NRD  = 3,
  localparam int PI_W = $clog2(NENT)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NRD-1:0][PI_W-1:0] rd_idx_i,
  output logic [NRD-1:0][DW-1:0]   rd_data_o,
  input  logic                     we_i,
  input  logic [PI_W-1:0]          widx_i,
  input  logic [DW-1:0]            wdata_i
);
  logic [DW-1:0] ent_q [NENT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NENT; i++) ent_q[i] <= '0;
    end else if (we_i) begin
      ent_q[widx_i] <= wdata_i;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_data_o[p] = ent_q[rd_idx_i[p]];
  end
endmodule

// File: rtl/rwin_seq.sv
module rwin_seq #(
  parameter int NWIN    = 8,
  parameter int NREG    = 8,
  parameter int FRAME_W = 8,
  localparam int WIN_W = $clog2(NWIN),
  localparam int IDX_W = $clog2(NREG) + 1,
  localparam int WI_W  = WIN_W + IDX_W,
  localparam int MA_W  = FRAME_W + IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             call_i,
  input  logic             ret_i,
  input  logic             mem_ready_i,
  output logic [WIN_W-1:0] cwp_o,
  output logic [WIN_W-1:0] swp_o,
  output logic             busy_o,
  output logic             ovf_o,
  output logic             unf_o,
  output logic             mem_valid_o,
  output logic             mem_we_o,
  output logic [MA_W-1:0]  mem_addr_o,
  output logic [WI_W-1:0]  seq_widx_o,
  output logic             seq_we_o
);
  import rwin_pkg::*;

  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(2 * NREG - 1);

  seq_state_e         st_q, st_d;
  logic [WIN_W-1:0]   cwp_q, cwp_d, bot_q, bot_d;
  logic [FRAME_W-1:0] frames_q, frames_d;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic               call_v, ret_v, ovf_hit, at_bot, last_beat;
  logic [WIN_W-1:0]   tgt_win;

  assign call_v    = call_i & ~ret_i;
  assign ret_v     = ret_i & ~call_i;
  assign ovf_hit   = (cwp_q + WIN_W'(2)) == bot_q;
  assign at_bot    = cwp_q == bot_q;
  assign last_beat = mem_ready_i && (idx_q == IDX_LAST);

  always_comb begin
    st_d     = st_q;
    cwp_d    = cwp_q;
    bot_d    = bot_q;
    frames_d = frames_q;
    idx_d    = idx_q;
    unique case (st_q)
      SQ_IDLE: begin
        idx_d = '0;
        if (call_v) begin
          if (ovf_hit) st_d = SQ_SPILL;
          else         cwp_d = cwp_q + WIN_W'(1);
        end else if (ret_v) begin
          if (!at_bot)               cwp_d = cwp_q - WIN_W'(1);
          else if (frames_q != '0)   st_d  = SQ_FILL;
        end
      end
      SQ_SPILL: begin
        if (mem_ready_i) idx_d = idx_q + IDX_W'(1);
        if (last_beat) begin
          st_d     = SQ_IDLE;
          bot_d    = bot_q + WIN_W'(1);
          frames_d = frames_q + FRAME_W'(1);
          cwp_d    = cwp_q + WIN_W'(1);
        end
      end
      SQ_FILL: begin
        if (mem_ready_i) idx_d = idx_q + IDX_W'(1);
        if (last_beat) begin
          st_d     = SQ_IDLE;
          bot_d    = bot_q - WIN_W'(1);
          frames_d = frames_q - FRAME_W'(1);
          cwp_d    = cwp_q - WIN_W'(1);
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= SQ_IDLE;
      cwp_q    <= '0;
      bot_q    <= '0;
      frames_q <= '0;
      idx_q    <= '0;
    end else begin
      st_q     <= st_d;
      cwp_q    <= cwp_d;
      bot_q    <= bot_d;
      frames_q <= frames_d;
      idx_q    <= idx_d;
    end
  end

  // spill drains the oldest resident window; fill restores the one below it
  assign tgt_win     = (st_q == SQ_FILL) ? bot_q - WIN_W'(1) : bot_q;
  assign seq_widx_o  = {tgt_win, idx_q};
  assign seq_we_o    = (st_q == SQ_FILL) && mem_ready_i;

  assign cwp_o       = cwp_q;
  assign swp_o       = bot_q - WIN_W'(1);
  assign busy_o      = st_q != SQ_IDLE;
  assign ovf_o       = st_q == SQ_SPILL;
  assign unf_o       = st_q == SQ_FILL;
  assign mem_valid_o = st_q != SQ_IDLE;
  assign mem_we_o    = st_q == SQ_SPILL;
  assign mem_addr_o  = (st_q == SQ_FILL) ? {frames_q - FRAME_W'(1), idx_q}
                                         : {frames_q, idx_q};
endmodule

// File: rtl/rwin_file.sv
module rwin_file #(
  parameter int NWIN    = 8,
  parameter int NREG    = 8,
  parameter int DW      = 32,
  parameter int FRAME_W = 8,
  localparam int WIN_W = $clog2(NWIN),
  localparam int OFF_W = $clog2(NREG),
  localparam int LA_W  = OFF_W + 2,
  localparam int IDX_W = OFF_W + 1,
  localparam int WI_W  = WIN_W + IDX_W,
  localparam int MA_W  = FRAME_W + IDX_W,
  localparam int NWREG = NWIN * 2 * NREG,
  localparam int NENT  = NWREG + NREG,
  localparam int PI_W  = $clog2(NENT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             call_i,
  input  logic             ret_i,
  input  logic [LA_W-1:0]  rd_a_addr_i,
  output logic [DW-1:0]    rd_a_data_o,
  input  logic [LA_W-1:0]  rd_b_addr_i,
  output logic [DW-1:0]    rd_b_data_o,
  input  logic             wr_en_i,
  input  logic [LA_W-1:0]  wr_addr_i,
  input  logic [DW-1:0]    wr_data_i,
  output logic             busy_o,
  output logic             ovf_o,
  output logic             unf_o,
  output logic [WIN_W-1:0] cwp_o,
  output logic [WIN_W-1:0] swp_o,
  output logic             mem_valid_o,
  output logic             mem_we_o,
  output logic [MA_W-1:0]  mem_addr_o,
  output logic [DW-1:0]    mem_wdata_o,
  input  logic             mem_ready_i,
  input  logic [DW-1:0]    mem_rdata_i
);
  localparam int NMAP = 3;  // read A, read B, write

  logic [NMAP-1:0][LA_W-1:0] la_all;
  logic [NMAP-1:0][PI_W-1:0] pidx_all;
  logic [2:0][PI_W-1:0]      rd_idx;
  logic [2:0][DW-1:0]        rd_data;
  logic [WI_W-1:0]           seq_widx;
  logic                      seq_we;
  logic                      st_we;
  logic [PI_W-1:0]           st_widx;
  logic [DW-1:0]             st_wdata;

  rwin_seq #(.NWIN(NWIN), .NREG(NREG), .FRAME_W(FRAME_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .call_i     (call_i),
    .ret_i      (ret_i),
    .mem_ready_i(mem_ready_i),
    .cwp_o      (cwp_o),
    .swp_o      (swp_o),
    .busy_o     (busy_o),
    .ovf_o      (ovf_o),
    .unf_o      (unf_o),
    .mem_valid_o(mem_valid_o),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .seq_widx_o (seq_widx),
    .seq_we_o   (seq_we)
  );

  assign la_all[0] = rd_a_addr_i;
  assign la_all[1] = rd_b_addr_i;
  assign la_all[2] = wr_addr_i;

  for (genvar m = 0; m < NMAP; m++) begin : g_map
    rwin_map #(.NWIN(NWIN), .NREG(NREG)) u_map (
      .la_i  (la_all[m]),
      .cwp_i (cwp_o),
      .pidx_o(pidx_all[m])
    );
  end

  assign rd_idx[0] = pidx_all[0];
  assign rd_idx[1] = pidx_all[1];
  assign rd_idx[2] = PI_W'(seq_widx);

  always_comb begin
    if (seq_we) begin
      st_we    = 1'b1;
      st_widx  = PI_W'(seq_widx);
      st_wdata = mem_rdata_i;
    end else begin
      st_we    = wr_en_i & ~busy_o;
      st_widx  = pidx_all[2];
      st_wdata = wr_data_i;
    end
  end

  rwin_store #(.DW(DW), .NENT(NENT), .NRD(3)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_idx_i (rd_idx),
    .rd_data_o(rd_data),
    .we_i     (st_we),
    .widx_i   (st_widx),
    .wdata_i  (st_wdata)
  );

  assign rd_a_data_o = rd_data[0];
  assign rd_b_data_o = rd_data[1];
  assign mem_wdata_o = rd_data[2];
endmodule

// File: rtl/rwin_file_chk.sv
module rwin_file_chk #(
  parameter int WIN_W = 3,
  parameter int MA_W  = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             call_i,
  input logic             ret_i,
  input logic             busy_o,
  input logic             ovf_o,
  input logic             unf_o,
  input logic [WIN_W-1:0] cwp_o,
  input logic [WIN_W-1:0] swp_o,
  input logic             mem_valid_o,
  input logic             mem_we_o,
  input logic [MA_W-1:0]  mem_addr_o,
  input logic             mem_ready_i
);
  p_step_call_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && call_i && !ret_i) |=> (busy_o || cwp_o == WIN_W'($past(cwp_o) + 1)));

  p_ovf_entry_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> WIN_W'($past(cwp_o) + 1) == $past(swp_o));

  p_spill_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> (mem_valid_o && mem_we_o));

  p_mem_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && !mem_ready_i) |=> (mem_valid_o && $stable(mem_addr_o)));

  p_swp_spill_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ovf_o) |-> swp_o == WIN_W'($past(swp_o) + 1));

  p_fill_read_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_o |-> (mem_valid_o && !mem_we_o && !ovf_o));

  p_busy_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (!busy_o || $stable(cwp_o)));

  p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_valid_o);

  p_both_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && call_i && ret_i) |=> $stable(cwp_o));
endmodule

bind rwin_file rwin_file_chk #(.WIN_W(WIN_W), .MA_W(MA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .call_i     (call_i),
  .ret_i      (ret_i),
  .busy_o     (busy_o),
  .ovf_o      (ovf_o),
  .unf_o      (unf_o),
  .cwp_o      (cwp_o),
  .swp_o      (swp_o),
  .mem_valid_o(mem_valid_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .mem_ready_i(mem_ready_i)
);

// File: tb/rwin_file_test.sv
module rwin_file_test;
  localparam int NW  = 8;
  localparam int NR  = 8;
  localparam int DW  = 32;
  localparam int FW  = 8;
  localparam int MAW = FW + 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic           call_i = 0, ret_i = 0, wr_en_i = 0, mem_ready_i = 0;
  logic [4:0]     rd_a_addr_i = 0, rd_b_addr_i = 0, wr_addr_i = 0;
  logic [DW-1:0]  wr_data_i = 0, rd_a_data_o, rd_b_data_o, mem_wdata_o, mem_rdata_i;
  logic           busy_o, ovf_o, unf_o, mem_valid_o, mem_we_o;
  logic [2:0]     cwp_o, swp_o;
  logic [MAW-1:0] mem_addr_o;

  rwin_file #(.NWIN(NW), .NREG(NR), .DW(DW), .FRAME_W(FW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .call_i(call_i), .ret_i(ret_i),
    .rd_a_addr_i(rd_a_addr_i), .rd_a_data_o(rd_a_data_o),
    .rd_b_addr_i(rd_b_addr_i), .rd_b_data_o(rd_b_data_o),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .busy_o(busy_o), .ovf_o(ovf_o), .unf_o(unf_o),
    .cwp_o(cwp_o), .swp_o(swp_o),
    .mem_valid_o(mem_valid_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_ready_i(mem_ready_i), .mem_rdata_i(mem_rdata_i)
  );

  logic [DW-1:0] bmem [0:1023];
  assign mem_rdata_i = bmem[mem_addr_o[9:0]];

  int errors = 0, checks = 0;
  logic [DW-1:0] ref_r [0:135];
  logic [DW-1:0] rstk [0:63][0:15];
  int rcwp = 0, rbot = 0, rdep = 0;

  // memory responder: random ready, capture spill writes before the handshake edge
  always @(negedge clk) begin : resp
    logic r;
    r = ($urandom % 3) != 0;
    mem_ready_i = r;
    if (r && mem_valid_o && mem_we_o) bmem[mem_addr_o[9:0]] = mem_wdata_o;
  end

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R3 / R2 mapping computed from the requirement text
  function automatic int pmap(input int la, input int cw);
    if (la < 8) return NW * 16 + la;
    return (cw * 16 + la - 8) % (NW * 16);
  endfunction

  task automatic rd2(input int la, input int lb, input string tag);
    rd_a_addr_i = 5'(la);
    rd_b_addr_i = 5'(lb);
    #1;
    chk({tag, " port A"}, rd_a_data_o, ref_r[pmap(la, rcwp)]);
    chk({tag, " port B"}, rd_b_data_o, ref_r[pmap(lb, rcwp)]);
  endtask

  task automatic wr(input int la, input logic [DW-1:0] val);
    wr_en_i = 1; wr_addr_i = 5'(la); wr_data_i = val;
    @(posedge clk); @(negedge clk);
    wr_en_i = 0;
    ref_r[pmap(la, rcwp)] = val;
  endtask

  task automatic wait_idle();
    for (int n = 0; n < 200; n++) begin
      if (!busy_o) break;
      @(negedge clk);
    end
    wr_en_i = 0;
  endtask

  task automatic check_ptrs(input string tag);
    chk({tag, " cwp"}, 32'(cwp_o), 32'(rcwp));
    chk({tag, " swp"}, 32'(swp_o), 32'((rbot + NW - 1) % NW));
  endtask

  task automatic do_call(input bit poke);
    bit exp_ovf;
    exp_ovf = ((rcwp + 2) % NW) == rbot;
    call_i = 1;
    @(posedge clk); @(negedge clk);
    call_i = 0;
    chk("R5 busy after call", 32'(busy_o), 32'(exp_ovf));
    chk("R5 ovf after call", 32'(ovf_o), 32'(exp_ovf));
    if (exp_ovf) begin
      for (int k = 0; k < 16; k++) rstk[rdep][k] = ref_r[rbot * 16 + k];
      chk("R5 cwp held during spill", 32'(cwp_o), 32'(rcwp));
      if (poke) begin  // R10: write and extra call while busy must be dropped
        wr_en_i = 1; wr_addr_i = 5'd0; wr_data_i = 32'hdead_beef; call_i = 1;
        @(posedge clk); @(negedge clk);
        call_i = 0;
      end
      wait_idle();
      for (int k = 0; k < 16; k++)
        chk("R6 spilled word", bmem[rdep * 16 + k], rstk[rdep][k]);
      rbot = (rbot + 1) % NW;
      rdep++;
    end
    rcwp = (rcwp + 1) % NW;
    check_ptrs(exp_ovf ? "R7 after spill" : "R4 after call");
  endtask

  task automatic do_ret();
    int mode;
    if (rcwp != rbot) mode = 0;
    else if (rdep > 0) mode = 1;
    else mode = 2;
    ret_i = 1;
    @(posedge clk); @(negedge clk);
    ret_i = 0;
    chk("R8 busy after ret", 32'(busy_o), 32'(mode == 1));
    chk("R8 unf after ret", 32'(unf_o), 32'(mode == 1));
    if (mode == 1) begin
      wait_idle();
      rdep--;
      rbot = (rbot + NW - 1) % NW;
      for (int k = 0; k < 16; k++) ref_r[rbot * 16 + k] = rstk[rdep][k];
      rcwp = rbot;
      check_ptrs("R8 after fill");
    end else if (mode == 0) begin
      rcwp = (rcwp + NW - 1) % NW;
      check_ptrs("R4 after ret");
    end else begin
      check_ptrs("R9 ret ignored");
    end
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    for (int i = 0; i < 136; i++) ref_r[i] = '0;
    for (int i = 0; i < 1024; i++) bmem[i] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1 cwp", 32'(cwp_o), 0);
    chk("R1 swp", 32'(swp_o), NW - 1);
    chk("R1 busy", 32'(busy_o), 0);
    chk("R1 ovf/unf", 32'({ovf_o, unf_o}), 0);
    chk("R1 mem_valid", 32'(mem_valid_o), 0);
    rd2(9, 17, "R1 zero regs");

    // R9 return with nothing to return to
    do_ret();

    // R11 write then read through both ports
    wr(5, 32'h1111_0005);
    wr(20, 32'h2222_0014);
    rd2(5, 20, "R11 readback");

    // R2 globals visible after a call, R3 outgoing aliases incoming
    wr(26, 32'h3333_001a);
    do_call(0);
    rd2(5, 10, "R2 R3 after call");
    wr(12, 32'h4444_000c);
    do_ret();
    rd2(28, 26, "R3 back in caller");

    // R12 call and ret together
    call_i = 1; ret_i = 1;
    @(posedge clk); @(negedge clk);
    call_i = 0; ret_i = 0;
    chk("R12 cwp unchanged", 32'(cwp_o), 32'(rcwp));
    chk("R12 not busy", 32'(busy_o), 0);

    // R5/R6/R7/R10: deep call chain wrapping the buffer twice
    for (int d = 0; d < 18; d++) begin
      wr(16 + (d % 8), 32'h5000_0000 + 32'(d));
      wr(24 + (d % 8), 32'h6000_0000 + 32'(d));
      do_call(d == 7);
      rd2(0, 8 + (d % 8), "R10 R3 chain read");
    end
    // R8 unwind all of it, restoring spilled frames
    for (int d = 0; d < 19; d++) begin
      do_ret();
      rd2(16 + (d % 8), 8 + (d % 8), "R8 unwind read");
    end

    // random mix
    for (int it = 0; it < 600; it++) begin
      int op;
      op = $urandom % 5;
      case (op)
        0: if (rdep < 40) do_call(($urandom % 4) == 0);
        1: do_ret();
        2, 3: wr($urandom % 32, $urandom);
        default: rd2($urandom % 32, $urandom % 32, "R3 R11 random read");
      endcase
    end
    while (rcwp != rbot || rdep > 0) begin
      do_ret();
      rd2($urandom % 32, $urandom % 32, "R8 final unwind");
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule